// File: doc/BRIEF.md
# Two-Master Interrupt Aggregator

This block gathers 112 interrupt inputs into a single summary interrupt line for a host processor. The inputs form 14 groups of 8. Seven groups belong to a first master and seven to a second. Each input passes through a synchroniser. A rising edge of the synchronised level sets a pending bit, and that bit stays set until software clears it. Every group has its own directly addressed registers, so no group-select step comes before an access: a pending view, a clear port, an enable mask and a live-level view.

Each master has a summary register. In that register, bit n (n = 1..7) is set when group n of that master has at least one pending input that is not masked. Bit 0 of the first master's summary is a chain flag that reports whether the second master has anything to report. The output interrupt is the OR of the first master's summary register. A handler therefore reads one register first, and reads the second master only when the chain bit is set. To acknowledge an input, software masks it and then writes a 1 to its clear bit.

Top module: `irqagg_top`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, and `irq_out` is 0.
- R2: A low-to-high transition of input k = (m*7 + b - 1)*8 + i, where m is the master (0 or 1), b is the group (1..7) and i is the bit (0..7), sets pending bit i of group b of master m. That pending byte reads at base(m) + b, where base(0) = 0x130 and base(1) = 0x1B0. An input that stays high does not set the bit again after a clear.
- R3: The mask byte of group b reads and writes at base(m) + b + 8. A mask bit of 1 keeps that input out of the summaries, and a mask bit of 0 lets it through. Masking never changes the pending bits.
- R4: A write to base(m) + b + 1 clears each pending bit of group b whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R5: When a rising edge and a clear of the same bit fall in the same cycle, the pending bit ends up set.
- R6: The byte at base(m) + b + 15 returns the synchronised present level of the 8 inputs of group b.
- R7: A read of base(m) returns the summary of master m. Bit b (1..7) is the OR of the pending bits of group b ANDed with the inverted mask bits. Bit 0 of the second master's summary always reads 0.
- R8: Bit 0 of the first master's summary is 1 exactly when some summary bit 1..7 of the second master is 1.
- R9: `irq_out` is 1 exactly when some unmasked pending bit exists anywhere, which is the OR of the first master's summary.
- R10: Reads of unmapped addresses return 0, and this includes base(m) + 8. Writes to summary, pending and level addresses change nothing.
- R11: A high-to-low transition of an input never sets a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 112 | Raw interrupt inputs, asynchronous |
| addr | input | 9 | Register address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| irq_out | output | 1 | Summary interrupt |

## Verification
The address map is the first target. A clear port sits one byte above a pending view, so the clear for group b shares its address with the pending view of group b+1. A decoder that mixed up read and write decode would clear the wrong group, or would let a write to a pending view destroy state; the directed writes to those addresses would expose either fault. The chain bit is checked by raising an input in the last group of the second master. A design with a missing or inverted chain bit would leave `irq_out` low while the second master reports. The same-cycle edge-and-clear case is timed to the cycle. A design that let the clear win would silently lose the interrupt. Random toggles, mask writes and clears run against a bench model, and falling edges and held-high inputs are included so that any design that latches on level would show extra pending bits.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
    // Offsets within a master window, relative to base + group number.
    localparam int unsigned OFF_CLR  = 1;
    localparam int unsigned OFF_MASK = 8;
    localparam int unsigned OFF_LVL  = 15;
    localparam int unsigned NUM_MASTERS = 2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SUMMARY,
        ACC_PEND,
        ACC_CLEAR,
        ACC_MASK,
        ACC_LEVEL
    } acc_e;
endpackage

// File: rtl/irqagg_sync.sv
`timescale 1ns/1ps
module irqagg_sync #(
    parameter int unsigned W      = 112,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [STAGES-1:0][W-1:0] chain;
    logic [W-1:0]             prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < int'(STAGES); s++) begin
                chain[s] <= chain[s-1];
            end
            prev <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/irqagg_bank.sv
`timescale 1ns/1ps
module irqagg_bank #(
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] rise,
    input  logic          clr_we,
    input  logic          mask_we,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] pend,
    output logic [BW-1:0] mask,
    output logic          flag
);
    logic [BW-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            mask <= '1;
        end else begin
            // a new edge wins over a clear in the same cycle
            pend <= (pend & ~clr_bits) | rise;
            if (mask_we) begin
                mask <= wdata;
            end
        end
    end

    assign flag = |(pend & ~mask);
endmodule

// File: rtl/irqagg_decode.sv
`timescale 1ns/1ps
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int unsigned         ADDR_W  = 9,
    parameter int unsigned         BPM     = 7,
    parameter int unsigned         BLK_W   = 3,
    parameter logic [ADDR_W-1:0]   M0_BASE = 'h130,
    parameter logic [ADDR_W-1:0]   M1_BASE = 'h1B0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              master,
    output acc_e              rd_acc,
    output acc_e              wr_acc,
    output logic [BLK_W-1:0]  rd_blk,
    output logic [BLK_W-1:0]  wr_blk
);
    localparam int unsigned SPAN = OFF_LVL + BPM + 1;

    logic [ADDR_W-1:0] off0, off1;
    logic              in0, in1;
    logic [31:0]       o;

    assign off0 = addr - M0_BASE;
    assign off1 = addr - M1_BASE;
    assign in0  = (addr >= M0_BASE) && (32'(off0) < SPAN);
    assign in1  = (addr >= M1_BASE) && (32'(off1) < SPAN);

    always_comb begin
        master = 1'b0;
        o      = '0;
        rd_acc = ACC_NONE;
        wr_acc = ACC_NONE;
        rd_blk = '0;
        wr_blk = '0;
        if (in0 || in1) begin
            master = !in0;
            o      = in0 ? 32'(off0) : 32'(off1);
            if (o == 0) begin
                rd_acc = ACC_SUMMARY;
            end else if (o <= BPM) begin
                rd_acc = ACC_PEND;
                rd_blk = BLK_W'(o);
            end else if (o > OFF_MASK && o <= OFF_MASK + BPM) begin
                rd_acc = ACC_MASK;
                rd_blk = BLK_W'(o - OFF_MASK);
            end else if (o > OFF_LVL && o <= OFF_LVL + BPM) begin
                rd_acc = ACC_LEVEL;
                rd_blk = BLK_W'(o - OFF_LVL);
            end
            if (o > OFF_CLR && o <= OFF_CLR + BPM) begin
                wr_acc = ACC_CLEAR;
                wr_blk = BLK_W'(o - OFF_CLR);
            end else if (o > OFF_MASK && o <= OFF_MASK + BPM) begin
                wr_acc = ACC_MASK;
                wr_blk = BLK_W'(o - OFF_MASK);
            end
        end
    end
endmodule

// File: rtl/irqagg_top.sv
`timescale 1ns/1ps
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned       BW          = 8,
    parameter int unsigned       ADDR_W      = 9,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] M0_BASE     = 'h130,
    parameter logic [ADDR_W-1:0] M1_BASE     = 'h1B0,
    localparam int unsigned      BPM         = BW - 1,
    localparam int unsigned      NBLK        = NUM_MASTERS * BPM,
    localparam int unsigned      NIRQ        = NBLK * BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIRQ-1:0]   irq_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BW-1:0]     wdata,
    output logic [BW-1:0]     rdata,
    output logic              irq_out
);
    localparam int unsigned BLK_W = $clog2(BPM + 1);
    localparam int unsigned GB_W  = $clog2(NBLK + 1);

    function automatic logic [GB_W-1:0] to_g(input logic m, input logic [BLK_W-1:0] b);
        return GB_W'(32'(m) * BPM + 32'(b) - 1);
    endfunction

    logic [NIRQ-1:0]                   lvl_flat, rise_flat;
    logic [NBLK-1:0][BW-1:0]           pend, mask, lvl;
    logic [NBLK-1:0]                   flag;
    logic [NUM_MASTERS-1:0][BW-1:0]    msum;
    logic                              master;
    acc_e                              rd_acc, wr_acc;
    logic [BLK_W-1:0]                  rd_blk, wr_blk;
    logic [GB_W-1:0]                   rd_g, wr_g;

    irqagg_sync #(.W(NIRQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_in),
        .level (lvl_flat),
        .rise  (rise_flat)
    );

    irqagg_decode #(
        .ADDR_W(ADDR_W), .BPM(BPM), .BLK_W(BLK_W),
        .M0_BASE(M0_BASE), .M1_BASE(M1_BASE)
    ) u_dec (
        .addr   (addr),
        .master (master),
        .rd_acc (rd_acc),
        .wr_acc (wr_acc),
        .rd_blk (rd_blk),
        .wr_blk (wr_blk)
    );

    assign rd_g = to_g(master, rd_blk);
    assign wr_g = to_g(master, wr_blk);
    assign lvl  = lvl_flat;

    for (genvar g = 0; g < NBLK; g++) begin : g_bank
        irqagg_bank #(.BW(BW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise_flat[g*BW +: BW]),
            .clr_we  (wr_en && wr_acc == ACC_CLEAR && wr_g == GB_W'(g)),
            .mask_we (wr_en && wr_acc == ACC_MASK  && wr_g == GB_W'(g)),
            .wdata   (wdata),
            .pend    (pend[g]),
            .mask    (mask[g]),
            .flag    (flag[g])
        );
    end

    always_comb begin
        msum = '0;
        for (int m = 0; m < int'(NUM_MASTERS); m++) begin
            for (int b = 1; b <= int'(BPM); b++) begin
                msum[m][b] = flag[m*BPM + b - 1];
            end
        end
        msum[0][0] = |msum[1][BW-1:1];
    end

    assign irq_out = |msum[0];

    always_comb begin
        unique case (rd_acc)
            ACC_SUMMARY: rdata = msum[master];
            ACC_PEND:    rdata = pend[rd_g];
            ACC_MASK:    rdata = mask[rd_g];
            ACC_LEVEL:   rdata = lvl[rd_g];
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqagg_chk.sv
`timescale 1ns/1ps
module irqagg_chk #(
    parameter int unsigned       NIRQ    = 112,
    parameter int unsigned       ADDR_W  = 9,
    parameter logic [ADDR_W-1:0] M0_BASE = 'h130,
    parameter logic [ADDR_W-1:0] M1_BASE = 'h1B0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        rdata,
    input logic              irq_out,
    input logic [NIRQ-1:0]   pend_flat,
    input logic [NIRQ-1:0]   mask_flat,
    input logic [NIRQ-1:0]   lvl_flat
);
    localparam int unsigned HALF = NIRQ / 2;

    logic mapped;
    assign mapped = ((addr >= M0_BASE) && (addr <= M0_BASE + 22) && (addr != M0_BASE + 8)) ||
                    ((addr >= M1_BASE) && (addr <= M1_BASE + 22) && (addr != M1_BASE + 8));

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_flat == '1 && pend_flat == '0));

    p_set_needs_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_flat & ~$past(pend_flat) & ~$past(lvl_flat)) == '0);

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> (mask_flat == $past(mask_flat)));

    p_drop_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend_flat) & ~pend_flat)) |-> $past(wr_en));

    p_chain_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == M0_BASE) |-> (rdata[0] == |(pend_flat[NIRQ-1:HALF] & ~mask_flat[NIRQ-1:HALF])));

    p_irq_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == |(pend_flat & ~mask_flat));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == 8'h00));
endmodule

bind irqagg_top irqagg_chk #(
    .NIRQ(NIRQ), .ADDR_W(ADDR_W), .M0_BASE(M0_BASE), .M1_BASE(M1_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rdata     (rdata),
    .irq_out   (irq_out),
    .pend_flat (pend),
    .mask_flat (mask),
    .lvl_flat  (lvl_flat)
);

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [111:0] irq_in = '0;
    logic [8:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [111:0] m_pend = '0;
    logic [111:0] m_mask = '1;
    logic [111:0] m_in = '0;

    always #2.5 clk = ~clk;

    irqagg_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [8:0] gaddr(int g, int off);
        logic [8:0] base = (g / 7 != 0) ? 9'h1B0 : 9'h130;
        return base + 9'(g % 7 + 1) + 9'(off);
    endfunction

    function automatic logic [7:0] exp_sum(int m);
        logic [7:0] s = '0;
        for (int b = 1; b <= 7; b++) begin
            int g = m * 7 + b - 1;
            s[b] = |(m_pend[g*8 +: 8] & ~m_mask[g*8 +: 8]);
        end
        if (m == 0) begin
            for (int b = 1; b <= 7; b++) begin
                int g = 7 + b - 1;
                s[0] = s[0] | (|(m_pend[g*8 +: 8] & ~m_mask[g*8 +: 8]));
            end
        end
        return s;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        wr_en = 1'b0;
        #1;
        d = rdata;
    endtask

    task automatic wr(logic [8:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive(logic [111:0] v);
        @(negedge clk);
        irq_in = v;
        repeat (4) @(posedge clk);
        m_pend = m_pend | (v & ~m_in);
        m_in = v;
    endtask

    task automatic chk_irq(string req);
        @(negedge clk);
        #1;
        chk(req, {7'd0, irq_out}, {7'd0, |(m_pend & ~m_mask)});
    endtask

    task automatic scan(string req);
        logic [7:0] d;
        for (int g = 0; g < 14; g++) begin
            rd(gaddr(g, 0), d);
            chk({req, " pending"}, d, m_pend[g*8 +: 8]);
        end
        rd(9'h130, d); chk({req, " summary0"}, d, exp_sum(0));
        rd(9'h1B0, d); chk({req, " summary1"}, d, exp_sum(1));
        chk_irq(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int unsigned seed;
        logic [111:0] v;
        seed = 32'd4321;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int g = 0; g < 14; g++) begin
            rd(gaddr(g, 8), d); chk("R1 mask", d, 8'hFF);
        end
        scan("R1");

        // R2 edge latch, masked: input 3 = m0 g1 bit3
        v = m_in; v[3] = 1'b1; drive(v);
        rd(9'h131, d); chk("R2 pending", d, 8'h08);
        chk_irq("R3 masked");
        rd(9'h130, d); chk("R3 summary masked", d, 8'h00);
        // R6 level view
        rd(9'h130 + 1 + 15, d); chk("R6 level", d, 8'h08);
        // R3 unmask
        wr(9'h139, 8'h00); m_mask[7:0] = 8'h00;
        rd(9'h139, d); chk("R3 mask readback", d, 8'h00);
        rd(9'h130, d); chk("R7 summary bit1", d, 8'h02);
        chk_irq("R9 asserted");
        // R4 zero clear has no effect, then clear
        wr(9'h132, 8'h00);
        rd(9'h131, d); chk("R4 zero clear", d, 8'h08);
        wr(9'h132, 8'h08); m_pend[3] = 1'b0;
        repeat (4) @(posedge clk);
        rd(9'h131, d); chk("R4 cleared, R2 held level no reset", d, 8'h00);
        chk_irq("R9 deasserted");
        // R11 falling edge
        v = m_in; v[3] = 1'b0; drive(v);
        rd(9'h131, d); chk("R11 falling edge", d, 8'h00);

        // R8 chain: input 104 = m1 g7 bit0
        v = m_in; v[104] = 1'b1; drive(v);
        wr(9'h1BF, 8'h00); m_mask[104 +: 8] = 8'h00;
        rd(9'h1B0, d); chk("R7 summary1", d, 8'h80);
        rd(9'h130, d); chk("R8 chain bit", d, 8'h01);
        chk_irq("R9 via chain");
        wr(9'h1BF, 8'h01); m_mask[104] = 1'b1;
        rd(9'h130, d); chk("R8 chain cleared by mask", d, 8'h00);
        rd(9'h1B7, d); chk("R3 mask keeps pending", d, 8'h01);

        // R10 unmapped and read-only addresses
        rd(9'h138, d); chk("R10 offset 8", d, 8'h00);
        rd(9'h100, d); chk("R10 unmapped low", d, 8'h00);
        rd(9'h1C7, d); chk("R10 unmapped high", d, 8'h00);
        wr(9'h1B1, 8'hFF);
        wr(9'h130, 8'hFF);
        wr(9'h1B0 + 7 + 15, 8'hFF);
        rd(9'h1B7, d); chk("R10 write to read-only", d, 8'h01);
        rd(9'h1B1 + 8, d); chk("R10 mask untouched", d, 8'hFF);

        // R5 edge and clear in same cycle: input 8 = m0 g2 bit0
        v = m_in; v[8] = 1'b1; drive(v);
        v[8] = 1'b0; drive(v);
        @(negedge clk); irq_in[8] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); addr = 9'h133; wdata = 8'h01; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        m_in[8] = 1'b1; m_pend[8] = 1'b1;
        rd(9'h132, d); chk("R5 set wins", d, 8'h01);

        // random phase
        for (int it = 0; it < 160; it++) begin
            int unsigned sel = $urandom_range(0, 2);
            int unsigned g = $urandom_range(0, 13);
            logic [7:0] r = 8'($urandom);
            if (sel == 0) begin
                v = m_in;
                for (int k = 0; k < 3; k++) v[$urandom_range(0, 111)] ^= 1'b1;
                drive(v);
            end else if (sel == 1) begin
                wr(gaddr(int'(g), 8), r); m_mask[g*8 +: 8] = r;
            end else begin
                wr(gaddr(int'(g), 1), r); m_pend[g*8 +: 8] &= ~r;
            end
            rd(gaddr(int'(g), 0), d); chk("R2 R4 random pending", d, m_pend[g*8 +: 8]);
            rd(gaddr(int'(g), 15), d); chk("R6 random level", d, m_in[g*8 +: 8]);
            if (it % 20 == 19) scan("R7 R8 R9 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule